// File: doc/BRIEF.md
# Synthesizer Divider Configuration Register File

This block holds the divider setting of a frequency synthesizer: a ten-bit feedback divider M, two three-bit output dividers NA and NB, and a one-bit prescaler select P. It sits on a two-wire I2C bus as a target device and can also be configured from hardware strap pins. A mode input picks the source. In serial mode the outputs keep their value until a complete three-byte I2C write replaces it. In parallel mode the outputs and the readable registers follow the strap pins, and I2C writes are acknowledged but have no effect.

The configuration is seen over the bus as three byte registers. Byte 0 is M[7:0]. Byte 1 is {M[9:8], NA[2:0], NB[2:0]}. Byte 2 is {P, 4'b0000, lock, ADR[1:0]}. A write always starts at byte 0, covers all three bytes, and applies all of them together when the third byte arrives. A read always starts at byte 0 and streams the bytes in turn, wrapping after byte 2. SCL and SDA are sampled and synchronized on the system clock, so the system clock must be much faster than SCL. The block drives SDA through an active-high pull-down enable.

Top module: `synth_cfg_regfile`

## Requirements
- R1: While rst_n is low the outputs hold M=0x271, NA=0, NB=0, P=1, and sda_oe is 0.
- R2: On the first clock after rst_n rises, the outputs load the strap pins, whatever the level of ser_mode.
- R3: The block acknowledges only the 7-bit address {5'b11011, adr_pins}. For any other address it leaves SDA released during the acknowledge bit.
- R4: In serial mode (ser_mode=1) a write of bytes b0, b1, b2 sets M={b1[7:6],b0}, NA=b1[5:3], NB=b1[2:0] and P=b2[7]. The outputs do not change before b2 has been received. Bytes after b2 are acknowledged and discarded.
- R5: A write that ends with STOP or repeated START before b2 leaves the outputs unchanged.
- R6: Bits 6..0 of byte 2 ignore written data. On read, bits 6..3 are 0, bit 2 is the live lock_i and bits 1..0 are the live adr_pins.
- R7: A read returns byte 0, byte 1 and byte 2 in that order. A fourth byte wraps to byte 0.
- R8: A master NACK ends a read and SDA is released, so the next transfer proceeds normally.
- R9: In parallel mode (ser_mode=0) the outputs take the strap pins within one clock and keep following them. Addressed writes are acknowledged and their data is discarded.
- R10: In parallel mode a read returns the pin configuration currently driven on the outputs.
- R11: In serial mode, with no complete write, the outputs hold their value even when the pins change. This includes the value held over from parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| ser_mode | input | 1 | 1 = serial programming, 0 = follow pins |
| pin_m | input | 10 | Strap value for M |
| pin_na | input | 3 | Strap value for NA |
| pin_nb | input | 3 | Strap value for NB |
| pin_p | input | 1 | Strap value for P |
| adr_pins | input | 2 | Low bits of the bus address, readable in byte 2 |
| lock_i | input | 1 | Lock status, readable in byte 2 |
| div_m | output | 10 | Registered M divider |
| div_na | output | 3 | Registered NA divider |
| div_nb | output | 3 | Registered NB divider |
| div_p | output | 1 | Registered P select |

## Verification
Writes are sent as full three-byte bursts, as bursts cut off by STOP or by repeated START, as bursts with an extra fourth byte, and to a wrong address. These cases show the atomic commit apart from per-byte updates, and address matching apart from acknowledging every address. Reads cover three bytes, a wrapping fourth byte and a NACK-terminated burst, with lock_i changed between reads so that live status bits can be told apart from stored ones. Mode changes are run in both directions while the pins move, which tells pin tracking apart from held configuration.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    parameter int M_W    = 10;
    parameter int N_W    = 3;
    parameter int BYTE_W = 8;
    parameter int NREGS  = 3;
    localparam int IDX_W = $clog2(NREGS + 1);

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] na;
        logic [N_W-1:0] nb;
        logic           p;
    } div_cfg_t;

    localparam div_cfg_t CFG_DEFAULT = '{m: 10'h271, na: 3'd0, nb: 3'd0, p: 1'b1};

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK
    } bus_state_e;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    typedef struct packed {
        logic [STAGES-1:0] scl_ff;
        logic [STAGES-1:0] sda_ff;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_ff   = {sync_q.scl_ff[STAGES-2:0], scl_i};
        sync_d.sda_ff   = {sync_q.sda_ff[STAGES-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl_ff[STAGES-1];
        sync_d.sda_prev = sync_q.sda_ff[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_s    = sync_q.scl_ff[STAGES-1];
    assign sda_s    = sync_q.sda_ff[STAGES-1];
    assign scl_rise = scl_s & ~sync_q.scl_prev;
    assign scl_fall = ~scl_s & sync_q.scl_prev;
    assign start_p  = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_p   = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;
endmodule

// File: rtl/synth_cfg_engine.sv
module synth_cfg_engine
    import synth_cfg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_s,
    input  logic                      sda_s,
    input  logic                      scl_rise,
    input  logic                      scl_fall,
    input  logic                      start_p,
    input  logic                      stop_p,
    input  logic [6:0]                dev_addr,
    input  logic [NREGS*BYTE_W-1:0]   rd_bytes,
    output logic                      wr_valid,
    output logic [BYTE_W-1:0]         wr_byte,
    output logic [IDX_W-1:0]          wr_idx,
    output logic                      sda_oe
);
    localparam logic [3:0]       BIT_LAST = 4'(BYTE_W);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(NREGS - 1);
    localparam logic [IDX_W-1:0] IDX_OVER = IDX_W'(NREGS);

    typedef struct packed {
        bus_state_e        st;
        logic [BYTE_W-1:0] sh;
        logic [3:0]        cnt;
        logic              rw;
        logic              nack;
        logic              oe;
        logic [IDX_W-1:0]  idx;
        logic              wv;
        logic [BYTE_W-1:0] wb;
        logic [IDX_W-1:0]  wi;
    } eng_t;

    eng_t eng_d, eng_q;

    function automatic logic [BYTE_W-1:0] pick(input logic [IDX_W-1:0] i);
        logic [BYTE_W-1:0] r;
        r = rd_bytes[(NREGS-1)*BYTE_W +: BYTE_W];
        for (int k = 0; k < NREGS; k++)
            if (i == IDX_W'(k)) r = rd_bytes[k*BYTE_W +: BYTE_W];
        return r;
    endfunction

    always_comb begin
        logic [IDX_W-1:0]  nxt;
        logic [BYTE_W-1:0] nb;
        eng_d    = eng_q;
        eng_d.wv = 1'b0;
        nxt      = (eng_q.idx == IDX_TOP) ? '0 : eng_q.idx + 1'b1;
        nb       = pick(nxt);
        if (start_p) begin
            eng_d.st  = S_ADDR;
            eng_d.cnt = '0;
            eng_d.oe  = 1'b0;
            eng_d.idx = '0;
        end else if (stop_p) begin
            eng_d.st = S_IDLE;
            eng_d.oe = 1'b0;
        end else begin
            unique case (eng_q.st)
                S_IDLE: ;
                S_ADDR: begin
                    if (scl_rise) begin
                        eng_d.sh  = {eng_q.sh[BYTE_W-2:0], sda_s};
                        eng_d.cnt = eng_q.cnt + 4'd1;
                    end else if (scl_fall && eng_q.cnt == BIT_LAST) begin
                        if (eng_q.sh[BYTE_W-1:1] == dev_addr) begin
                            eng_d.st = S_ADDR_ACK;
                            eng_d.oe = 1'b1;
                            eng_d.rw = eng_q.sh[0];
                        end else begin
                            eng_d.st = S_IDLE;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        eng_d.cnt = '0;
                        if (eng_q.rw) begin
                            eng_d.sh = pick(eng_q.idx);
                            eng_d.oe = ~pick(eng_q.idx)[BYTE_W-1];
                            eng_d.st = S_RD;
                        end else begin
                            eng_d.oe = 1'b0;
                            eng_d.st = S_WR;
                        end
                    end
                end
                S_WR: begin
                    if (scl_rise) begin
                        eng_d.sh  = {eng_q.sh[BYTE_W-2:0], sda_s};
                        eng_d.cnt = eng_q.cnt + 4'd1;
                    end else if (scl_fall && eng_q.cnt == BIT_LAST) begin
                        eng_d.oe  = 1'b1;
                        eng_d.st  = S_WR_ACK;
                        eng_d.wv  = 1'b1;
                        eng_d.wb  = eng_q.sh;
                        eng_d.wi  = eng_q.idx;
                        eng_d.idx = (eng_q.idx == IDX_OVER) ? IDX_OVER : eng_q.idx + 1'b1;
                    end
                end
                S_WR_ACK: begin
                    if (scl_fall) begin
                        eng_d.oe  = 1'b0;
                        eng_d.cnt = '0;
                        eng_d.st  = S_WR;
                    end
                end
                S_RD: begin
                    if (scl_rise) begin
                        eng_d.cnt = eng_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (eng_q.cnt == BIT_LAST) begin
                            eng_d.oe = 1'b0;
                            eng_d.st = S_RD_ACK;
                        end else begin
                            eng_d.sh = {eng_q.sh[BYTE_W-2:0], 1'b0};
                            eng_d.oe = ~eng_q.sh[BYTE_W-2];
                        end
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise) begin
                        eng_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (eng_q.nack) begin
                            eng_d.st = S_IDLE;
                        end else begin
                            eng_d.idx = nxt;
                            eng_d.sh  = nb;
                            eng_d.oe  = ~nb[BYTE_W-1];
                            eng_d.cnt = '0;
                            eng_d.st  = S_RD;
                        end
                    end
                end
                default: eng_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q    <= '0;
            eng_q.st <= S_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign wr_valid = eng_q.wv;
    assign wr_byte  = eng_q.wb;
    assign wr_idx   = eng_q.wi;
    assign sda_oe   = eng_q.oe;

    // R3
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(eng_q.oe) |-> (!$past(scl_s) || $past(start_p) || $past(stop_p)));

    // R7
    rd_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == S_RD) |-> (eng_q.idx <= IDX_TOP));
endmodule

// File: rtl/synth_cfg_regfile.sv
module synth_cfg_regfile
    import synth_cfg_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b11011
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_i,
    input  logic           sda_i,
    output logic           sda_oe,
    input  logic           ser_mode,
    input  logic [M_W-1:0] pin_m,
    input  logic [N_W-1:0] pin_na,
    input  logic [N_W-1:0] pin_nb,
    input  logic           pin_p,
    input  logic [1:0]     adr_pins,
    input  logic           lock_i,
    output logic [M_W-1:0] div_m,
    output logic [N_W-1:0] div_na,
    output logic [N_W-1:0] div_nb,
    output logic           div_p
);
    localparam int RSV_W = BYTE_W - 4;

    typedef struct packed {
        div_cfg_t          cfg;
        logic              boot;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
    } rf_t;

    rf_t rf_d, rf_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic                    wr_valid;
    logic [BYTE_W-1:0]       wr_byte;
    logic [IDX_W-1:0]        wr_idx;
    logic [NREGS*BYTE_W-1:0] rd_bytes;
    div_cfg_t                pin_cfg;

    synth_cfg_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    synth_cfg_engine u_engine (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
        .dev_addr({ADDR_PREFIX, adr_pins}), .rd_bytes(rd_bytes),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_idx(wr_idx), .sda_oe(sda_oe)
    );

    assign pin_cfg  = '{m: pin_m, na: pin_na, nb: pin_nb, p: pin_p};
    assign rd_bytes = {
        {rf_q.cfg.p, {RSV_W{1'b0}}, lock_i, adr_pins},
        {rf_q.cfg.m[M_W-1:BYTE_W], rf_q.cfg.na, rf_q.cfg.nb},
        rf_q.cfg.m[BYTE_W-1:0]
    };

    always_comb begin
        rf_d      = rf_q;
        rf_d.boot = 1'b0;
        if (rf_q.boot || !ser_mode) begin
            rf_d.cfg = pin_cfg;
        end else if (wr_valid) begin
            case (wr_idx)
                IDX_W'(0): rf_d.b0 = wr_byte;
                IDX_W'(1): rf_d.b1 = wr_byte;
                IDX_W'(2): rf_d.cfg = '{m:  {rf_q.b1[BYTE_W-1 -: 2], rf_q.b0},
                                        na: rf_q.b1[5:3],
                                        nb: rf_q.b1[2:0],
                                        p:  wr_byte[BYTE_W-1]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q      <= '0;
            rf_q.cfg  <= CFG_DEFAULT;
            rf_q.boot <= 1'b1;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign div_m  = rf_q.cfg.m;
    assign div_na = rf_q.cfg.na;
    assign div_nb = rf_q.cfg.nb;
    assign div_p  = rf_q.cfg.p;

    // R2
    boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q.boot |=> ({div_m, div_na, div_nb, div_p} == $past({pin_m, pin_na, pin_nb, pin_p})));

    // R9
    par_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_mode |=> ({div_m, div_na, div_nb, div_p} == $past({pin_m, pin_na, pin_nb, pin_p})));

    // R11
    ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && !rf_q.boot && !(wr_valid && wr_idx == IDX_W'(2)))
        |=> $stable({div_m, div_na, div_nb, div_p}));
endmodule

// File: tb/test_synth_cfg_regfile.sv
module test_synth_cfg_regfile;
    localparam int Q = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, ser_mode, scl_drv, sda_drv, lock, pp;
    logic [9:0] pm;
    logic [2:0] pna, pnb;
    logic [1:0] adr;
    logic       sda_oe, sda_line;
    logic [9:0] div_m;
    logic [2:0] div_na, div_nb;
    logic       div_p;

    assign sda_line = sda_drv & ~sda_oe;

    synth_cfg_regfile i_synth_cfg_regfile (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
        .ser_mode(ser_mode), .pin_m(pm), .pin_na(pna), .pin_nb(pnb), .pin_p(pp),
        .adr_pins(adr), .lock_i(lock),
        .div_m(div_m), .div_na(div_na), .div_nb(div_nb), .div_p(div_p)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    typedef struct { string req; int val; } item_t;
    item_t exp_q[$];
    int    got_q[$];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cfgv(input int m, input int na, input int nb, input int p);
        return (m << 7) | (na << 4) | (nb << 1) | p;
    endfunction

    function automatic int outv();
        return int'({div_m, div_na, div_nb, div_p});
    endfunction

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(input int m, input int na, input int nb, input int p);
        pm = 10'(m); pna = 3'(na); pnb = 3'(nb); pp = 1'(p);
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; wq(Q); scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b0; wq(Q); scl_drv = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; wq(Q); scl_drv = 1'b1; wq(Q); sda_drv = 1'b1; wq(Q);
    endtask

    task automatic wbit(input logic b);
        sda_drv = b; wq(Q); scl_drv = 1'b1; wq(2 * Q); scl_drv = 1'b0; wq(Q);
    endtask

    task automatic rbit(output logic b);
        sda_drv = 1'b1; wq(Q); scl_drv = 1'b1; wq(Q); b = sda_line;
        wq(Q); scl_drv = 1'b0; wq(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, input string req, input bit exp_ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        chk(req, int'(!a), int'(exp_ack));
    endtask

    task automatic get_byte(input bit give_ack);
        logic [7:0] v;
        logic b;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            rbit(b);
            v = {v[6:0], b};
        end
        wbit(!give_ack);
        got_q.push_back(int'(v));
    endtask

    task automatic expect_rd(input string req, input int v);
        item_t it;
        it.req = req; it.val = v;
        exp_q.push_back(it);
    endtask

    // monitor: pairs each received byte with the next expected one
    initial begin
        forever begin
            item_t it;
            int g;
            wait (exp_q.size() > 0 && got_q.size() > 0);
            it = exp_q.pop_front();
            g  = got_q.pop_front();
            chk(it.req, g, it.val);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ser_mode = 1'b1; scl_drv = 1'b1; sda_drv = 1'b1;
        lock = 1'b1; adr = 2'b10;
        set_pins(10'h155, 3, 5, 0);
        wq(5);
        chk("R1 reset dividers", outv(), cfgv(10'h271, 0, 0, 1));
        chk("R1 reset sda_oe", int'(sda_oe), 0);

        rst_n = 1'b1;
        wq(2);
        chk("R2 pins loaded at reset release", outv(), cfgv(10'h155, 3, 5, 0));

        set_pins(10'h0F0, 1, 1, 1);
        wq(4);
        chk("R11 serial hold on pin change", outv(), cfgv(10'h155, 3, 5, 0));

        // wrong address
        bus_start;
        put_byte(8'hD8, "R3 foreign address not acked", 1'b0);
        bus_stop;

        // full serial write with a trailing extra byte
        bus_start;
        put_byte(8'hDC, "R3 own address acked", 1'b1);
        put_byte(8'h3C, "R4 byte0 ack", 1'b1);
        put_byte(8'hD6, "R4 byte1 ack", 1'b1);
        chk("R4 no update before byte2", outv(), cfgv(10'h155, 3, 5, 0));
        put_byte(8'hFF, "R4 byte2 ack", 1'b1);
        chk("R4 commit after byte2", outv(), cfgv(10'h33C, 2, 6, 1));
        put_byte(8'hAA, "R4 extra byte acked", 1'b1);
        bus_stop;
        chk("R4 extra byte discarded", outv(), cfgv(10'h33C, 2, 6, 1));

        // read of four bytes, wrap, master NACK
        bus_start;
        put_byte(8'hDD, "R3 read address acked", 1'b1);
        expect_rd("R7 read byte0", 8'h3C);
        expect_rd("R7 read byte1", 8'hD6);
        expect_rd("R6 read byte2 status bits", 8'h86);
        expect_rd("R7 wrap to byte0", 8'h3C);
        get_byte(1'b1); get_byte(1'b1); get_byte(1'b1); get_byte(1'b0);
        wq(4);
        chk("R8 sda released after NACK", int'(sda_oe), 0);
        bus_stop;

        // burst cut by STOP
        bus_start;
        put_byte(8'hDC, "R5 address ack", 1'b1);
        put_byte(8'h11, "R5 byte0 ack", 1'b1);
        put_byte(8'h22, "R5 byte1 ack", 1'b1);
        bus_stop;
        chk("R5 cut by stop", outv(), cfgv(10'h33C, 2, 6, 1));

        // burst cut by repeated START, then read with live lock low
        lock = 1'b0;
        bus_start;
        put_byte(8'hDC, "R5 address ack", 1'b1);
        put_byte(8'h11, "R5 byte0 ack", 1'b1);
        put_byte(8'h22, "R5 byte1 ack", 1'b1);
        bus_start;
        put_byte(8'hDD, "R8 next transfer after NACK", 1'b1);
        chk("R5 cut by repeated start", outv(), cfgv(10'h33C, 2, 6, 1));
        expect_rd("R7 read byte0", 8'h3C);
        expect_rd("R7 read byte1", 8'hD6);
        expect_rd("R6 live lock low", 8'h82);
        get_byte(1'b1); get_byte(1'b1); get_byte(1'b0);
        bus_stop;

        // parallel mode
        ser_mode = 1'b0;
        wq(2);
        chk("R9 outputs take pins", outv(), cfgv(10'h0F0, 1, 1, 1));
        set_pins(10'h2A5, 7, 1, 1);
        wq(2);
        chk("R9 outputs follow pins", outv(), cfgv(10'h2A5, 7, 1, 1));
        bus_start;
        put_byte(8'hDC, "R9 address acked in parallel", 1'b1);
        put_byte(8'h00, "R9 byte0 acked", 1'b1);
        put_byte(8'h00, "R9 byte1 acked", 1'b1);
        put_byte(8'h00, "R9 byte2 acked", 1'b1);
        bus_stop;
        chk("R9 write discarded", outv(), cfgv(10'h2A5, 7, 1, 1));
        bus_start;
        put_byte(8'hDD, "R10 read address acked", 1'b1);
        expect_rd("R10 pin byte0", 8'hA5);
        expect_rd("R10 pin byte1", 8'hB9);
        expect_rd("R10 pin byte2", 8'h82);
        get_byte(1'b1); get_byte(1'b1); get_byte(1'b0);
        bus_stop;

        // back to serial mode
        ser_mode = 1'b1;
        wq(1);
        set_pins(10'h001, 0, 0, 0);
        wq(4);
        chk("R11 keeps last pin config", outv(), cfgv(10'h2A5, 7, 1, 1));
        bus_start;
        put_byte(8'hDC, "R4 address ack", 1'b1);
        put_byte(8'h01, "R4 byte0 ack", 1'b1);
        put_byte(8'h40, "R4 byte1 ack", 1'b1);
        put_byte(8'h00, "R4 byte2 ack", 1'b1);
        bus_stop;
        chk("R4 serial write after mode return", outv(), cfgv(10'h101, 0, 0, 0));

        wait (exp_q.size() == 0);
        wq(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule